// File: doc/BRIEF.md
# Stepped Soft-Start Current-Limit Sequencer

This block paces the startup of a switching regulator by raising its peak current-limit setting in equal steps. Counting runs only on a one-cycle tick that marks each oscillator period. There are five steps by default. The first step allows one fifth of full scale. Each later step adds another fifth once a fixed number of ticks has passed. After four full steps the limit stands at full scale and the sequence is complete.

An external comparator reports when the output is in regulation. If that happens before the ramp finishes, the sequencer ends at once: on the next clock the limit jumps to full scale and the done flag rises. The done flag holds until the controller is shut down, the input undervoltage flag is raised, or the block is reset. Any of these clears the step, the tick count and the flag, so the ramp starts again from the first step.

Top module: `soft_start_seq`

## Requirements
- R1: While `rst_ni` is low, and directly after it, `phase_o` is 0, `done_o` is 0 and `ilim_pct_o` is 20.
- R2: When `enable_i` is low or `uvlo_i` is high at a clock edge, that edge clears the phase to 0, clears `done_o` and clears the tick count. After release, a full 128 ticks are needed before phase 1.
- R3: While `done_o` is 0, `ilim_pct_o` equals 20·(phase+1), so phases 0 to 4 give 20, 40, 60, 80 and 100.
- R4: The phase advances by one on the clock edge that samples the 128th `tick_i` pulse of the current phase, and not before.
- R5: Clock edges with `tick_i` low do not change the phase or the tick count.
- R6: After 512 ticks without regulation, `phase_o` is 4, `ilim_pct_o` is 100 and `done_o` is 1.
- R7: When `in_reg_i` is high at an edge while enabled and not yet done, then after that edge `done_o` is 1, `ilim_pct_o` is 100 and `phase_o` is 4, whatever the tick count was.
- R8: Once set, `done_o` stays 1, with `ilim_pct_o` at 100, through any ticks and any level of `in_reg_i`, until a clear from R2 or a reset.
- R9: While the block is held cleared by R2, `in_reg_i` and `tick_i` have no effect: `done_o` stays 0 and `phase_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per oscillator period |
| enable_i | input | 1 | Controller enable; low means shutdown |
| uvlo_i | input | 1 | Input undervoltage lockout active |
| in_reg_i | input | 1 | Output has reached regulation |
| ilim_pct_o | output | 7 | Peak current-limit setting in percent of full scale |
| phase_o | output | 3 | Current soft-start phase, 0 to 4 |
| done_o | output | 1 | Soft-start finished |

## Verification
The ramp is run from start to finish twice: once with a tick on every clock and once with two idle clocks between ticks. Each phase is checked one tick before and exactly at its boundary, which separates counting on ticks from counting on clocks and catches off-by-one step lengths. Early termination is applied in every phase at offsets 0, 1, 64 and 127 into the phase, showing that the jump to full scale does not depend on the count. A lockout in the middle of the ramp, followed by a new full phase, shows that the clear resets the tick counter as well as the phase. Inputs driven while the block is disabled show that they are ignored.

// File: rtl/ss_pkg.sv
package ss_pkg;
  // current-limit percentage granted in step idx (0-based)
  function automatic int unsigned step_pct(int unsigned idx, int unsigned steps,
                                           int unsigned full);
    return ((idx + 1) * full) / steps;
  endfunction
endpackage

// File: rtl/ss_cycle_counter.sv
module ss_cycle_counter #(
  parameter int unsigned STEP_CYCLES = 128,
  parameter int unsigned CNT_W       = $clog2(STEP_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic step_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv    = run_i & tick_i;
  assign step_o = adv & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (adv)     cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ss_phase_ctrl.sv
module ss_phase_ctrl #(
  parameter int unsigned NUM_STEPS = 5,
  parameter int unsigned PH_W      = $clog2(NUM_STEPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic            in_reg_i,
  output logic [PH_W-1:0] phase_o,
  output logic            done_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_STEPS - 1);

  logic [PH_W-1:0] phase_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      phase_q <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      if (in_reg_i) begin
        // early exit: regulation reached, open the limit fully
        phase_q <= PH_LAST;
        done_q  <= 1'b1;
      end else if (step_i) begin
        phase_q <= phase_q + 1'b1;
        done_q  <= (phase_q == PH_LAST - 1'b1);
      end
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ss_limit_map.sv
module ss_limit_map #(
  parameter int unsigned NUM_STEPS = 5,
  parameter int unsigned FULL_PCT  = 100,
  parameter int unsigned PH_W      = $clog2(NUM_STEPS),
  parameter int unsigned PCT_W     = $clog2(FULL_PCT + 1)
) (
  input  logic [PH_W-1:0]  phase_i,
  input  logic             done_i,
  output logic [PCT_W-1:0] pct_o
);
  logic [PCT_W-1:0] lut [NUM_STEPS];

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_lut
    assign lut[i] = PCT_W'(ss_pkg::step_pct(i, NUM_STEPS, FULL_PCT));
  end

  always_comb begin
    pct_o = PCT_W'(FULL_PCT);
    if (!done_i) begin
      for (int i = 0; i < NUM_STEPS; i++) begin
        if (phase_i == PH_W'(i)) pct_o = lut[i];
      end
    end
  end
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
  parameter int unsigned NUM_STEPS   = 5,
  parameter int unsigned STEP_CYCLES = 128,
  parameter int unsigned FULL_PCT    = 100,
  localparam int unsigned PH_W       = $clog2(NUM_STEPS),
  localparam int unsigned CNT_W      = $clog2(STEP_CYCLES),
  localparam int unsigned PCT_W      = $clog2(FULL_PCT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             uvlo_i,
  input  logic             in_reg_i,
  output logic [PCT_W-1:0] ilim_pct_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             done_o
);
  logic clr;
  logic step;

  assign clr = ~enable_i | uvlo_i;

  ss_cycle_counter #(
    .STEP_CYCLES(STEP_CYCLES),
    .CNT_W      (CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (~done_o),
    .tick_i(tick_i),
    .step_o(step)
  );

  ss_phase_ctrl #(
    .NUM_STEPS(NUM_STEPS),
    .PH_W     (PH_W)
  ) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .step_i  (step),
    .in_reg_i(in_reg_i),
    .phase_o (phase_o),
    .done_o  (done_o)
  );

  ss_limit_map #(
    .NUM_STEPS(NUM_STEPS),
    .FULL_PCT (FULL_PCT),
    .PH_W     (PH_W),
    .PCT_W    (PCT_W)
  ) u_map (
    .phase_i(phase_o),
    .done_i (done_o),
    .pct_o  (ilim_pct_o)
  );
endmodule

// File: rtl/soft_start_seq_chk.sv
module soft_start_seq_chk #(
  parameter int unsigned NUM_STEPS   = 5,
  parameter int unsigned STEP_CYCLES = 128,
  parameter int unsigned FULL_PCT    = 100,
  localparam int unsigned PH_W       = $clog2(NUM_STEPS),
  localparam int unsigned PCT_W      = $clog2(FULL_PCT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             enable_i,
  input logic             uvlo_i,
  input logic             in_reg_i,
  input logic [PCT_W-1:0] ilim_pct_o,
  input logic [PH_W-1:0]  phase_o,
  input logic             done_o
);
  logic clr_c;
  assign clr_c = ~enable_i | uvlo_i;

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_c |=> (phase_o == '0) && !done_o);

  assert_first_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && phase_o == '0) |-> ilim_pct_o == PCT_W'(FULL_PCT / NUM_STEPS));

  assert_no_adv_without_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_c && !tick_i && !in_reg_i) |=> $stable(phase_o) && $stable(done_o));

  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_c && !in_reg_i) |=> (phase_o == $past(phase_o)) || (phase_o == $past(phase_o) + 1'b1));

  assert_reg_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_c && in_reg_i) |=> done_o && (ilim_pct_o == PCT_W'(FULL_PCT)));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_c) |=> done_o);

  assert_done_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ilim_pct_o == PCT_W'(FULL_PCT)) && (phase_o == PH_W'(NUM_STEPS - 1)));
endmodule

bind soft_start_seq soft_start_seq_chk #(
  .NUM_STEPS  (NUM_STEPS),
  .STEP_CYCLES(STEP_CYCLES),
  .FULL_PCT   (FULL_PCT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .enable_i  (enable_i),
  .uvlo_i    (uvlo_i),
  .in_reg_i  (in_reg_i),
  .ilim_pct_o(ilim_pct_o),
  .phase_o   (phase_o),
  .done_o    (done_o)
);

// File: tb/soft_start_seq_bench.sv
module soft_start_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 5;
  localparam int PER        = 128;
  localparam int FULL       = 100;
  localparam int WDOG_MAX   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       uvlo = 1'b0;
  logic       inreg = 1'b0;
  logic [6:0] ilim;
  logic [2:0] phase;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  soft_start_seq u_soft_start_seq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .enable_i  (en),
    .uvlo_i    (uvlo),
    .in_reg_i  (inreg),
    .ilim_pct_o(ilim),
    .phase_o   (phase),
    .done_o    (done)
  );

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt == WDOG_MAX) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected < %0d", cyc_cnt, WDOG_MAX);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int eph, input int edone);
    int epct;
    epct = edone ? FULL : (FULL * (eph + 1)) / STEPS;
    chk({tag, " phase"}, int'(phase), eph);
    chk({tag, " done"}, int'(done), edone);
    chk({tag, " ilim"}, int'(ilim), epct);
  endtask

  task automatic cyc(input logic t, input logic r);
    tick = t;
    inreg = r;
    @(posedge clk);
    #1;
    tick = 1'b0;
    inreg = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0);
      repeat (gap) cyc(1'b0, 1'b0);
    end
  endtask

  task automatic do_clear();
    en = 1'b0;
    cyc(1'b0, 1'b0);
    en = 1'b1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk_state("R1 in reset", 0, 0);
    rst_n = 1'b1;
    en = 1'b1;
    cyc(1'b0, 1'b0);
    chk_state("R1 after reset", 0, 0);

    // R5: idle clocks without ticks do nothing
    repeat (300) cyc(1'b0, 1'b0);
    chk_state("R5 no tick", 0, 0);

    // R3 R4 R6: full ramp, dense and sparse ticks
    for (int gap = 0; gap <= 2; gap += 2) begin
      do_clear();
      for (int k = 1; k < STEPS; k++) begin
        ticks(PER - 1, gap);
        chk_state("R4 before boundary", k - 1, 0);
        ticks(1, gap);
        if (k == STEPS - 1) chk_state("R6 full reached", k, 1);
        else                chk_state("R3 step limit", k, 0);
      end
      // R8: stays done with more ticks
      ticks(200, gap);
      chk_state("R8 sticky after ramp", STEPS - 1, 1);
    end

    // R2: clear via enable low
    do_clear();
    chk_state("R2 enable clear", 0, 0);

    // R9: inputs ignored while disabled
    en = 1'b0;
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1);
    chk_state("R9 disabled ignores in_reg", 0, 0);
    en = 1'b1;

    // R2: undervoltage mid-ramp clears counter and phase
    do_clear();
    ticks(2 * PER + 3, 0);
    chk_state("R2 pre-uvlo", 2, 0);
    uvlo = 1'b1;
    cyc(1'b1, 1'b1);
    uvlo = 1'b0;
    chk_state("R2 uvlo clear", 0, 0);
    ticks(PER - 1, 0);
    chk_state("R2 counter restarted", 0, 0);
    ticks(1, 0);
    chk_state("R2 first step after uvlo", 1, 0);

    // R7 R8: early termination in every phase at several offsets
    for (int k = 0; k < STEPS - 1; k++) begin
      for (int j = 0; j < 4; j++) begin
        int off;
        off = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 64 : PER - 1;
        do_clear();
        ticks(k * PER + off, 0);
        chk_state("R7 before regulation", k, 0);
        cyc(1'b0, 1'b1);
        chk_state("R7 regulation exit", STEPS - 1, 1);
        ticks(PER + 5, 0);
        chk_state("R8 sticky after exit", STEPS - 1, 1);
      end
    end

    // R8: cleared only by shutdown
    do_clear();
    chk_state("R8 cleared by shutdown", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule